// File: doc/BRIEF.md
# MII Nibble Receive Deframer

This block sits behind the receive half of a 4-bit media-independent interface. On every rising edge of the receive clock it samples a data nibble, a data-valid flag and an error flag. When data-valid rises, the block skips any number of `0x5` preamble nibbles, starting with zero. It locks onto the `0xD` start delimiter and then pairs the following nibbles into bytes, low nibble first. The bytes leave as a beat stream that carries first and last markers.

A frame closes when data-valid is sampled low. In the same cycle as the last byte, a one-cycle status pulse reports four things: the CRC-32 result, whether the byte count falls inside the allowed window, whether the frame stopped on a half byte, and whether any nibble was marked bad. The receive side of the interface has no flow control, so the byte stream is valid-only. The consumer has no ready input and must take every beat in the cycle it appears. Back-pressure is not possible; a consumer that needs it must place its own buffer behind this block.

Top module: `mii_rx_deframer`

## Requirements
- R1: While data-valid is high before the delimiter, every `0x5` nibble is discarded, whatever the count (zero included). The nibble `0xD` is the delimiter, and the nibble after it is the low half of the first data byte.
- R2: Any nibble other than `0x5` or `0xD` before the delimiter drops the frame. The block then emits no byte and no status until data-valid is sampled low, after which the next frame is received normally.
- R3: Each output byte is `{second nibble, first nibble}`, with `rxd[0]` as the least significant bit of each nibble. Bytes leave in arrival order with `m_valid` high for one cycle each, and no beat is ever held back.
- R4: `m_first` is high only on the first byte of a frame. `m_last` is high only on its final byte, and that byte leaves in the cycle after data-valid is sampled low.
- R5: `sts_valid` pulses for exactly one cycle, once per frame that reached the delimiter, in the cycle after data-valid is sampled low. The status bits hold their values until the next pulse.
- R6: `sts_crc_err` is low only when a reflected CRC-32 (polynomial `0xEDB88320`, preset all ones, no final inversion) run over every whole byte, FCS included, ends equal to `0xDEBB20E3`.
- R7: `sts_len_err` is high when the count of whole bytes after the delimiter is below `MIN_LEN` or above `MAX_LEN` (defaults 64 and 1518).
- R8: `sts_align_err` is high when an odd number of nibbles followed the delimiter. The trailing half byte is discarded and is never emitted.
- R9: `sts_rx_err` is high when `rx_er` was sampled high together with data-valid at any point from the rise of data-valid to the end of the frame, preamble included.
- R10: During and right after reset, `m_valid`, `m_first`, `m_last`, `sts_valid` and all status bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error for the current nibble |
| rxd | input | 4 | Receive nibble, bit 0 least significant |
| m_valid | output | 1 | Byte beat valid |
| m_data | output | 8 | Received byte |
| m_first | output | 1 | Beat is the first byte of a frame |
| m_last | output | 1 | Beat is the final byte of a frame |
| sts_valid | output | 1 | One-cycle end-of-frame status strobe |
| sts_crc_err | output | 1 | CRC residue mismatch |
| sts_len_err | output | 1 | Byte count outside the allowed window |
| sts_align_err | output | 1 | Frame ended on a half byte |
| sts_rx_err | output | 1 | A nibble was flagged with rx_er |

## Verification
The bench builds the block with a narrow length window (4 to 12 bytes). It sweeps every frame length from 0 to 14 bytes against preambles of 0, 1, 7 and 15 nibbles. This separates correct delimiter lock, byte assembly and the length window edges from off-by-one faults at either boundary. Frames with a correct FCS are paired with frames whose FCS carries one flipped bit, which shows whether the residue compare reacts to the data at all. Single error nibbles placed in the preamble and at several data positions, trailing half bytes, and illegal pre-delimiter nibbles each followed by a clean frame show that each status bit responds only to its own cause and that a dropped frame leaves the block ready for the next one.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_DROP
  } rx_state_e;

  localparam logic [3:0]  NIB_PRE     = 4'h5;
  localparam logic [3:0]  NIB_SFD     = 4'hD;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  typedef struct packed {
    logic crc_err;
    logic len_err;
    logic align_err;
    logic rx_err;
  } rx_status_t;

  // One byte through the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                             input logic [7:0]  d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/mii_rx_sfd_fsm.sv
module mii_rx_sfd_fsm
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic [3:0] rxd,
  output rx_state_e  state_o,
  output logic       frm_begin,
  output logic       nib_en,
  output logic       frm_end
);

  rx_state_e st_q, st_nx;

  always_comb begin
    st_nx     = st_q;
    frm_begin = 1'b0;
    nib_en    = 1'b0;
    frm_end   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_PRE: begin
        if (!rx_dv) begin
          st_nx = ST_IDLE;
        end else if (rxd == NIB_SFD) begin
          st_nx     = ST_DATA;
          frm_begin = 1'b1;
        end else if (rxd == NIB_PRE) begin
          st_nx = ST_PRE;
        end else begin
          st_nx = ST_DROP;
        end
      end
      ST_DATA: begin
        if (rx_dv) begin
          nib_en = 1'b1;
        end else begin
          frm_end = 1'b1;
          st_nx   = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (!rx_dv) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  assign state_o = st_q;

endmodule

// File: rtl/mii_rx_nibble_pack.sv
module mii_rx_nibble_pack #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              nib_en,
  input  logic [NIB_W-1:0]  nib,
  output logic              byte_en,
  output logic [BYTE_W-1:0] byte_o,
  output logic              odd_o
);

  logic [NIB_W-1:0] lo_q;
  logic             odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      odd_q <= 1'b0;
    end else if (clear) begin
      odd_q <= 1'b0;
    end else if (nib_en) begin
      odd_q <= ~odd_q;
      if (!odd_q) lo_q <= nib;
    end
  end

  assign byte_en = nib_en & odd_q;
  assign byte_o  = {nib, lo_q};
  assign odd_o   = odd_q;

endmodule

// File: rtl/mii_rx_crc32.sv
module mii_rx_crc32
  import mii_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= CRC_PRESET;
    else if (clear) crc_q <= CRC_PRESET;
    else if (en)    crc_q <= crc32_byte(crc_q, data);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
  import mii_rx_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  localparam int CNT_W = $clog2(MAX_LEN + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic [3:0] rxd,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_first,
  output logic       m_last,
  output logic       sts_valid,
  output logic       sts_crc_err,
  output logic       sts_len_err,
  output logic       sts_align_err,
  output logic       sts_rx_err
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEN);

  rx_state_e   state;
  logic        frm_begin, nib_en, frm_end;
  logic        byte_en, odd;
  logic [7:0]  byte_w;
  logic [31:0] crc;

  mii_rx_sfd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_dv     (rx_dv),
    .rxd       (rxd),
    .state_o   (state),
    .frm_begin (frm_begin),
    .nib_en    (nib_en),
    .frm_end   (frm_end)
  );

  mii_rx_nibble_pack #(.NIB_W(4)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (frm_begin),
    .nib_en  (nib_en),
    .nib     (rxd),
    .byte_en (byte_en),
    .byte_o  (byte_w),
    .odd_o   (odd)
  );

  mii_rx_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (frm_begin),
    .en    (byte_en),
    .data  (byte_w),
    .crc_o (crc)
  );

  // Sticky receive-error flag, re-armed while the line is idle.
  logic er_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                er_q <= 1'b0;
    else if (state == ST_IDLE) er_q <= rx_dv & rx_er;
    else                       er_q <= er_q | (rx_dv & rx_er);
  end

  // Whole-byte counter, saturating just above the upper limit.
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (frm_begin)                  cnt_q <= '0;
    else if (byte_en && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  // One-byte hold stage so the final byte can carry the last marker.
  logic       hold_vld, hold_first;
  logic [7:0] hold_data;
  rx_status_t sts_nx;

  always_comb begin
    sts_nx.crc_err   = (crc != CRC_RESIDUE);
    sts_nx.len_err   = (cnt_q < CNT_MIN) || (cnt_q > CNT_MAX);
    sts_nx.align_err = odd;
    sts_nx.rx_err    = er_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld      <= 1'b0;
      hold_first    <= 1'b0;
      hold_data     <= '0;
      m_valid       <= 1'b0;
      m_data        <= '0;
      m_first       <= 1'b0;
      m_last        <= 1'b0;
      sts_valid     <= 1'b0;
      sts_crc_err   <= 1'b0;
      sts_len_err   <= 1'b0;
      sts_align_err <= 1'b0;
      sts_rx_err    <= 1'b0;
    end else begin
      m_valid   <= 1'b0;
      m_first   <= 1'b0;
      m_last    <= 1'b0;
      sts_valid <= 1'b0;
      if (frm_begin) begin
        hold_vld <= 1'b0;
      end else if (byte_en) begin
        m_valid    <= hold_vld;
        m_data     <= hold_data;
        m_first    <= hold_vld & hold_first;
        hold_vld   <= 1'b1;
        hold_data  <= byte_w;
        hold_first <= (cnt_q == '0);
      end else if (frm_end) begin
        m_valid       <= hold_vld;
        m_data        <= hold_data;
        m_first       <= hold_vld & hold_first;
        m_last        <= hold_vld;
        hold_vld      <= 1'b0;
        sts_valid     <= 1'b1;
        sts_crc_err   <= sts_nx.crc_err;
        sts_len_err   <= sts_nx.len_err;
        sts_align_err <= sts_nx.align_err;
        sts_rx_err    <= sts_nx.rx_err;
      end
    end
  end

endmodule

// File: rtl/mii_rx_deframer_checker.sv
module mii_rx_deframer_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_dv,
  input logic m_valid,
  input logic m_first,
  input logic m_last,
  input logic sts_valid
);

  assert_last_with_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_last) |-> sts_valid);

  assert_markers_need_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_first || m_last) |-> m_valid);

  assert_status_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> !sts_valid);

  assert_status_after_dv_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> $past(!rx_dv));

  assert_mid_byte_during_dv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |-> $past(rx_dv));

  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!m_valid && !sts_valid));

endmodule

bind mii_rx_deframer mii_rx_deframer_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_dv     (rx_dv),
  .m_valid   (m_valid),
  .m_first   (m_first),
  .m_last    (m_last),
  .sts_valid (sts_valid)
);

// File: tb/mii_rx_deframer_bench.sv
module mii_rx_deframer_bench;

  localparam int MINL = 4;
  localparam int MAXL = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_dv = 1'b0;
  logic       rx_er = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       m_valid, m_first, m_last, sts_valid;
  logic [7:0] m_data;
  logic       sts_crc_err, sts_len_err, sts_align_err, sts_rx_err;

  mii_rx_deframer #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) u_mii_rx_deframer (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .m_valid(m_valid), .m_data(m_data), .m_first(m_first), .m_last(m_last),
    .sts_valid(sts_valid), .sts_crc_err(sts_crc_err), .sts_len_err(sts_len_err),
    .sts_align_err(sts_align_err), .sts_rx_err(sts_rx_err)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] fb[$];
  logic [7:0] cd[$];
  bit         cf[$];
  bit         cl[$];
  int         sts_n;
  bit         s_crc, s_len, s_aln, s_er;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid) begin
        cd.push_back(m_data);
        cf.push_back(m_first);
        cl.push_back(m_last);
      end
      if (sts_valid) begin
        sts_n++;
        s_crc = sts_crc_err;
        s_len = sts_len_err;
        s_aln = sts_align_err;
        s_er  = sts_rx_err;
      end
    end
  end

  function automatic logic [31:0] crc_upd(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB8_8320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic drive(input logic [3:0] n, input logic dv, input logic er);
    @(negedge clk);
    rx_dv = dv;
    rxd   = n;
    rx_er = er;
  endtask

  task automatic clear_cap();
    cd.delete(); cf.delete(); cl.delete();
    sts_n = 0;
  endtask

  // Fill fb with a frame of len whole bytes; a correct FCS when len >= 4.
  task automatic build(input int len, input int seed);
    logic [31:0] c;
    fb.delete();
    c = 32'hFFFF_FFFF;
    if (len >= 4) begin
      for (int i = 0; i < len - 4; i++) begin
        fb.push_back(8'((i * 37 + seed * 11 + 3) & 8'hFF));
        c = crc_upd(c, fb[i]);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) fb.push_back(c[8*k +: 8]);
    end else begin
      for (int i = 0; i < len; i++) fb.push_back(8'((i * 53 + seed * 7 + 1) & 8'hFF));
    end
  endtask

  task automatic send(input int pre, input bit extra, input int er_idx, input bit er_pre);
    int n;
    clear_cap();
    for (int i = 0; i < pre; i++) drive(4'h5, 1'b1, er_pre && i == 0);
    drive(4'hD, 1'b1, er_pre && pre == 0);
    n = 0;
    foreach (fb[i]) begin
      drive(fb[i][3:0], 1'b1, n == er_idx); n++;
      drive(fb[i][7:4], 1'b1, n == er_idx); n++;
    end
    if (extra) drive(4'hA, 1'b1, n == er_idx);
    drive(4'h0, 1'b0, 1'b0);
    repeat (3) drive(4'h0, 1'b0, 1'b0);
  endtask

  task automatic verify(input string rq, input bit exp_aln, input bit exp_er);
    logic [31:0] c;
    int          n;
    bit          exp_crc, exp_len;
    n = fb.size();
    c = 32'hFFFF_FFFF;
    foreach (fb[i]) c = crc_upd(c, fb[i]);
    exp_crc = (c != 32'hDEBB_20E3);
    exp_len = (n < MINL) || (n > MAXL);
    chk(cd.size() == n, rq, "byte count", cd.size(), n);
    for (int i = 0; i < n && i < cd.size(); i++) begin
      chk(cd[i] == fb[i], "R3", "byte value", cd[i], fb[i]);
      chk(cf[i] == (i == 0), "R4", "first marker", cf[i], i == 0);
      chk(cl[i] == (i == n - 1), "R4", "last marker", cl[i], i == n - 1);
    end
    chk(sts_n == 1, "R5", "status pulses", sts_n, 1);
    chk(s_crc == exp_crc, "R6", "crc error", s_crc, exp_crc);
    chk(s_len == exp_len, "R7", "length error", s_len, exp_len);
    chk(s_aln == exp_aln, "R8", "alignment error", s_aln, exp_aln);
    chk(s_er == exp_er, "R9", "rx error", s_er, exp_er);
  endtask

  task automatic abort_case(input int pre, input logic [3:0] bad);
    clear_cap();
    for (int i = 0; i < pre; i++) drive(4'h5, 1'b1, 1'b0);
    drive(bad, 1'b1, 1'b0);
    drive(4'hD, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) drive(4'(i), 1'b1, 1'b0);
    drive(4'h0, 1'b0, 1'b0);
    repeat (3) drive(4'h0, 1'b0, 1'b0);
    chk(cd.size() == 0, "R2", "bytes from dropped frame", cd.size(), 0);
    chk(sts_n == 0, "R2", "status from dropped frame", sts_n, 0);
    build(6, pre + 40);
    send(2, 1'b0, -1, 1'b0);
    verify("R2", 1'b0, 1'b0);
  endtask

  initial begin
    sts_n = 0;
    repeat (3) @(negedge clk);
    chk(!m_valid && !m_first && !m_last, "R10", "byte outputs in reset",
        {m_valid, m_first, m_last}, 0);
    chk(!sts_valid && !sts_crc_err && !sts_len_err && !sts_align_err && !sts_rx_err,
        "R10", "status outputs in reset",
        {sts_valid, sts_crc_err, sts_len_err, sts_align_err, sts_rx_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && !sts_valid, "R10", "outputs after reset", {m_valid, sts_valid}, 0);

    // Length and preamble sweep (R1, R3..R7).
    for (int len = 0; len <= 14; len++) begin
      for (int p = 0; p < 4; p++) begin
        int pre;
        pre = (p == 0) ? 0 : (p == 1) ? 1 : (p == 2) ? 7 : 15;
        build(len, len + p);
        send(pre, 1'b0, -1, 1'b0);
        verify("R1", 1'b0, 1'b0);
      end
    end

    // Corrupted FCS at each length inside the window (R6).
    for (int len = MINL; len <= MAXL; len++) begin
      build(len, len + 9);
      fb[len - 1] = fb[len - 1] ^ 8'(1 << (len % 8));
      send(3, 1'b0, -1, 1'b0);
      verify("R6", 1'b0, 1'b0);
    end

    // Trailing half byte (R8).
    for (int len = 0; len <= 8; len += 4) begin
      build(len, len + 21);
      send(4, 1'b1, -1, 1'b0);
      verify("R8", 1'b1, 1'b0);
    end

    // Error nibble at several positions (R9).
    for (int e = 0; e < 16; e += 3) begin
      build(8, e);
      send(5, 1'b0, e, 1'b0);
      verify("R9", 1'b0, 1'b1);
    end
    build(8, 77);
    send(4, 1'b0, -1, 1'b1);
    verify("R9", 1'b0, 1'b1);
    build(8, 78);
    send(4, 1'b0, -1, 1'b0);
    verify("R9", 1'b0, 1'b0);

    // Illegal nibbles before the delimiter (R2).
    abort_case(0, 4'h0);
    abort_case(3, 4'h7);
    abort_case(6, 4'hF);
    abort_case(1, 4'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule